// File: doc/BRIEF.md
# Transport Packet Capture Buffer

This block gathers transport stream packets, already filtered upstream, into an on-chip buffer of eight fixed-size slots of 188 bytes each (1504 bytes). Packets arrive as a byte stream in which a start flag marks the first byte of each packet. Each completed packet bumps a stored-packet count. When the count reaches a programmed threshold, a buffer-ready flag is raised. A packet that begins while all eight slots are held is dropped and raises an overflow flag.

A single 32-bit control and status word carries all of the controls and status:
- the stored-packet count;
- four maskable interrupt sources: buffer-ready, overflow, almost-full and receiver lock;
- a write-one acknowledge that empties the buffer;
- an active-low run bit that holds the capture logic in reset;
- the threshold.

Software reads the captured bytes through a plain synchronous read port, then acknowledges so that capture starts again at slot 0.

Top module: `ts_capture_buf`

## Requirements
- R1: After reset the status word reads 0x00027004: all four masks set (bits 17, 14, 13, 12), run bit 15 clear, threshold (bits 6:0) equal to 4, count zero. The interrupt output is low.
- R2: Byte k of a packet stored with count c before it goes to buffer address c*188+k. A read returns the byte one clock after the address is presented. The count in bits 31:24 goes up by one on the clock that takes in the packet's 188th byte.
- R3: The count never exceeds 8. A packet whose start flag arrives while 8 packets are held is dropped whole. Buffer contents and count stay unchanged, and the overflow flag (bit 11) is set.
- R4: Buffer-ready flag bit 16 is set on each packet completion that leaves the count greater than or equal to the threshold in bits 6:0.
- R5: The interrupt output is high exactly when some source is active with its mask clear. The pairs are: buffer-ready bit 16 with mask bit 17, overflow bit 11 with mask bit 14, almost-full bit 10 with mask bit 13, and lock bit 9 with mask bit 12.
- R6: Almost-full status bit 10 reads 1 whenever the count is 7 or more.
- R7: Lock status bit 9 follows the lock input one clock later.
- R8: Writing 1 to bit 8 clears both flags, zeroes the count and abandons any partly received packet, so the next packet lands at offset 0. Bit 8 reads 0. Writes to bits 31:24, 16, 11, 10 and 9 have no effect.
- R9: While run bit 15 is 0, the count stays zero, both flags stay clear and incoming bytes are ignored.
- R10: Bytes without a start flag outside a packet are discarded. A start flag in the middle of a packet restarts that packet at offset 0 of the same slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet byte valid |
| in_sop | input | 1 | First byte of a packet |
| in_data | input | 8 | Packet byte |
| lock_in | input | 1 | Receiver lock status |
| reg_we | input | 1 | Write strobe for the status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current status word |
| irq | output | 1 | Interrupt request |
| rd_addr | input | 11 | Buffer read address |
| rd_data | output | 8 | Buffer byte, one clock after the address |

## Verification
A wrong slot counter shows up in two places. The count field is wrong on the negative edge right after the last byte of a packet. Bytes read back from the expected slot addresses are also wrong, one clock after the address is applied. A stuck flag or a wrong mask pairing shows on the interrupt pin in the same cycle as the status word, so each status read also compares the pin. A framing state left behind after an acknowledge or a mid-packet start becomes visible as a wrong count one packet later, and as stale bytes at offsets the new packet should have overwritten.

// File: rtl/tscap_pkg.sv
package tscap_pkg;

    // status word bit positions; software decodes these
    localparam int unsigned B_MASK_RDY = 17;
    localparam int unsigned B_RDY      = 16;
    localparam int unsigned B_RUN      = 15;
    localparam int unsigned B_MASK_OVF = 14;
    localparam int unsigned B_MASK_AF  = 13;
    localparam int unsigned B_MASK_LK  = 12;
    localparam int unsigned B_OVF      = 11;
    localparam int unsigned B_AF       = 10;
    localparam int unsigned B_LK       = 9;
    localparam int unsigned B_ACK      = 8;
    localparam int unsigned THR_W      = 7;
    localparam int unsigned CNT_FLD_W  = 8;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_FILL = 2'd1,
        FR_DROP = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic             mrdy;
        logic             rdy;
        logic             run;
        logic             movf;
        logic             maf;
        logic             mlk;
        logic             ovf;
        logic             lock;
        logic [THR_W-1:0] thr;
    } tsc_ctrl_t;

endpackage

// File: rtl/tscap_store.sv
module tscap_store #(
    parameter int unsigned DEPTH  = 1504,
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [0:DEPTH-1];
    logic [7:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_d = '0;
        if (rd_addr < ADDR_W'(DEPTH)) begin
            rd_d = mem[rd_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/tscap_framer.sv
module tscap_framer
    import tscap_pkg::*;
#(
    parameter int unsigned PKT_BYTES = 188,
    parameter int unsigned SLOTS     = 8,
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned OFS_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [CNT_W-1:0]  cnt,
    output logic              done,
    output logic [CNT_W-1:0]  done_cnt,
    output logic              ovf_hit
);

    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PKT_BYTES - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SLOTS);

    typedef struct packed {
        fr_state_e        state;
        logic [OFS_W-1:0] ofs;
        logic [CNT_W-1:0] cnt;
    } fr_t;

    fr_t              fr_d, fr_q;
    logic [OFS_W-1:0] wofs;

    always_comb begin
        fr_d     = fr_q;
        wr_en    = 1'b0;
        done     = 1'b0;
        ovf_hit  = 1'b0;
        wofs     = fr_q.ofs;
        if (clr) begin
            fr_d.state = FR_IDLE;
            fr_d.ofs   = '0;
            fr_d.cnt   = '0;
        end else if (in_valid) begin
            if (in_sop) begin
                if (fr_q.cnt == FULL_CNT) begin
                    ovf_hit    = 1'b1;
                    fr_d.state = FR_DROP;
                    fr_d.ofs   = '0;
                end else begin
                    wr_en      = 1'b1;
                    wofs       = '0;
                    fr_d.ofs   = OFS_W'(1);
                    fr_d.state = FR_FILL;
                end
            end else if (fr_q.state == FR_FILL) begin
                wr_en = 1'b1;
                if (fr_q.ofs == LAST_OFS) begin
                    fr_d.state = FR_IDLE;
                    fr_d.ofs   = '0;
                    fr_d.cnt   = fr_q.cnt + 1'b1;
                    done       = 1'b1;
                end else begin
                    fr_d.ofs = fr_q.ofs + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{state: FR_IDLE, ofs: '0, cnt: '0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign wr_addr  = ADDR_W'(fr_q.cnt) * ADDR_W'(PKT_BYTES) + ADDR_W'(wofs);
    assign wr_data  = in_data;
    assign cnt      = fr_q.cnt;
    assign done_cnt = fr_q.cnt + 1'b1;

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.cnt <= FULL_CNT); // R3
    AST_OVF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |=> (fr_q.cnt == FULL_CNT)); // R3
    AST_DONE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (fr_q.cnt != '0)); // R2
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fr_q.cnt == '0 && fr_q.state == FR_IDLE)); // R8

endmodule

// File: rtl/tscap_ctrl.sv
module tscap_ctrl
    import tscap_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    input  logic             lock_in,
    input  logic [CNT_W-1:0] cnt,
    input  logic             done,
    input  logic [CNT_W-1:0] done_cnt,
    input  logic             ovf_hit,
    output logic             clr,
    output logic [31:0]      reg_rdata,
    output logic             irq
);

    localparam logic [CNT_W-1:0] AF_LEVEL  = CNT_W'(SLOTS - 1);
    localparam logic [THR_W-1:0] RESET_THR = THR_W'(SLOTS / 2);

    tsc_ctrl_t c_d, c_q;
    logic      ack;
    logic      run_nx;
    logic      afull;
    logic      unused_wbits;

    assign ack    = reg_we & reg_wdata[B_ACK];
    assign run_nx = reg_we ? reg_wdata[B_RUN] : c_q.run;
    assign clr    = ack | ~run_nx;
    assign unused_wbits = ^{reg_wdata[31:18], reg_wdata[B_RDY], reg_wdata[B_OVF],
                            reg_wdata[B_AF], reg_wdata[B_LK], reg_wdata[7]};

    always_comb begin
        c_d      = c_q;
        c_d.lock = lock_in;
        if (reg_we) begin
            c_d.mrdy = reg_wdata[B_MASK_RDY];
            c_d.run  = reg_wdata[B_RUN];
            c_d.movf = reg_wdata[B_MASK_OVF];
            c_d.maf  = reg_wdata[B_MASK_AF];
            c_d.mlk  = reg_wdata[B_MASK_LK];
            c_d.thr  = reg_wdata[THR_W-1:0];
        end
        if (clr) begin
            c_d.rdy = 1'b0;
            c_d.ovf = 1'b0;
        end else begin
            if (done && (CNT_FLD_W'(done_cnt) >= CNT_FLD_W'(c_q.thr))) begin
                c_d.rdy = 1'b1;
            end
            if (ovf_hit) begin
                c_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{mrdy: 1'b1, rdy: 1'b0, run: 1'b0, movf: 1'b1, maf: 1'b1,
                     mlk: 1'b1, ovf: 1'b0, lock: 1'b0, thr: RESET_THR};
        end else begin
            c_q <= c_d;
        end
    end

    assign afull = (cnt >= AF_LEVEL);

    assign reg_rdata = {CNT_FLD_W'(cnt), 6'b0, c_q.mrdy, c_q.rdy, c_q.run, c_q.movf,
                        c_q.maf, c_q.mlk, c_q.ovf, afull, c_q.lock, 1'b0, 1'b0, c_q.thr};

    assign irq = (c_q.rdy & ~c_q.mrdy) | (c_q.ovf & ~c_q.movf)
               | (afull & ~c_q.maf) | (c_q.lock & ~c_q.mlk);

    AST_ACK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!c_q.rdy && !c_q.ovf)); // R8
    AST_RDY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.rdy) |-> $past(done)); // R4
    AST_LOCK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (c_q.lock == $past(lock_in))); // R7

endmodule

// File: rtl/ts_capture_buf.sv
module ts_capture_buf
    import tscap_pkg::*;
#(
    parameter  int unsigned PKT_BYTES = 188,
    parameter  int unsigned SLOTS     = 8,
    localparam int unsigned DEPTH     = PKT_BYTES * SLOTS,
    localparam int unsigned ADDR_W    = $clog2(DEPTH),
    localparam int unsigned CNT_W     = $clog2(SLOTS + 1),
    localparam int unsigned OFS_W     = $clog2(PKT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_data,
    input  logic              lock_in,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic              clr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [CNT_W-1:0]  cnt;
    logic              done;
    logic [CNT_W-1:0]  done_cnt;
    logic              ovf_hit;

    tscap_framer #(
        .PKT_BYTES(PKT_BYTES), .SLOTS(SLOTS), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .OFS_W(OFS_W)
    ) i_framer (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt(cnt), .done(done), .done_cnt(done_cnt), .ovf_hit(ovf_hit)
    );

    tscap_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    tscap_ctrl #(.SLOTS(SLOTS), .CNT_W(CNT_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .lock_in(lock_in),
        .cnt(cnt), .done(done), .done_cnt(done_cnt), .ovf_hit(ovf_hit),
        .clr(clr), .reg_rdata(reg_rdata), .irq(irq)
    );

    AST_HALT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[B_RUN] |-> (reg_rdata[31:24] == 8'd0 && !reg_rdata[B_RDY] && !reg_rdata[B_OVF])); // R9
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_rdata[B_RDY] | reg_rdata[B_OVF] | reg_rdata[B_AF] | reg_rdata[B_LK])); // R5

endmodule

// File: tb/test_ts_capture_buf.sv
module test_ts_capture_buf;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 13;
    localparam int OP_CHK = 0, OP_WR = 1, OP_SEND = 2;

    // {op[66:65], arg[64:33], expected word[32:1], expected irq[0]}
    localparam logic [66:0] VEC [NVEC] = '{
        {2'd0, 32'h0,        32'h0002_7004, 1'b0}, // R1 reset word
        {2'd1, 32'h0000_8004, 32'h0000_8004, 1'b0}, // R5 run, all unmasked
        {2'd2, 32'd3,        32'h0300_8004, 1'b0}, // R2 count 3
        {2'd2, 32'd1,        32'h0401_8004, 1'b1}, // R4 threshold reached
        {2'd1, 32'h0002_8104, 32'h0002_8004, 1'b0}, // R8 ack clears
        {2'd2, 32'd7,        32'h0703_8404, 1'b1}, // R6 almost full drives irq
        {2'd1, 32'h0002_A004, 32'h0703_A404, 1'b0}, // R5 afull masked
        {2'd2, 32'd1,        32'h0803_A404, 1'b0}, // R3 count 8
        {2'd2, 32'd1,        32'h0803_AC04, 1'b1}, // R3 overflow flag
        {2'd1, 32'h0002_E104, 32'h0002_E004, 1'b0}, // R8 ack
        {2'd1, 32'hFF01_8E02, 32'h0000_8002, 1'b0}, // R8 read-only bits ignored
        {2'd2, 32'd2,        32'h0201_8002, 1'b1}, // R4 threshold 2
        {2'd1, 32'h0000_8102, 32'h0000_8002, 1'b0}  // R8 ack
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        lock_in = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [10:0] rd_addr = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    int pkt_id = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ts_capture_buf i_ts_capture_buf (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .lock_in(lock_in), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] pb(int pid, int idx);
        return 8'((pid * 37 + idx * 3 + 1) & 255);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_bytes(int pid, int first, int n, bit with_sop);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = with_sop && (k == 0);
            in_data  = pb(pid, first + k);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    task automatic send_pkt();
        send_bytes(pkt_id, 0, 188, 1'b1);
        pkt_id++;
    endtask

    task automatic reg_write(logic [31:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(string tag, int slot, int off, int pid);
        @(negedge clk);
        rd_addr = 11'(slot * 188 + off);
        @(negedge clk);
        chk(tag, {24'b0, rd_data}, {24'b0, pb(pid, off)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int p0, p1, p8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            case (int'(VEC[v][66:65]))
                OP_WR:   reg_write(VEC[v][64:33]);
                OP_SEND: for (int j = 0; j < int'(VEC[v][64:33]); j++) send_pkt();
                default: @(negedge clk);
            endcase
            chk($sformatf("table[%0d] word", v), reg_rdata, VEC[v][32:1]);
            chk($sformatf("table[%0d] irq", v), {31'b0, irq}, {31'b0, VEC[v][0]});
        end

        // R10: stray bytes outside a packet are dropped
        send_bytes(99, 0, 5, 1'b0);
        chk("R10 stray bytes", reg_rdata, 32'h0000_8002);

        // R2: slot placement and read latency
        p0 = pkt_id;
        send_pkt();
        send_pkt();
        rd_chk("R2 slot0 first", 0, 0, p0);
        rd_chk("R2 slot0 last", 0, 187, p0);
        rd_chk("R2 slot1 first", 1, 0, p0 + 1);
        rd_chk("R2 slot1 mid", 1, 100, p0 + 1);

        // R8: acknowledge aborts a partial packet
        reg_write(32'h0000_8102);
        send_bytes(200, 0, 100, 1'b1);
        reg_write(32'h0000_8102);
        send_bytes(200, 100, 88, 1'b0);
        chk("R8 partial dropped", reg_rdata, 32'h0000_8002);
        p1 = pkt_id;
        send_pkt();
        chk("R8 count after ack", {24'b0, reg_rdata[31:24]}, 32'd1);
        rd_chk("R8 restart offset 0", 0, 0, p1);
        rd_chk("R8 restart offset 150", 0, 150, p1);

        // R10: a start flag mid-packet restarts the same slot
        reg_write(32'h0000_8102);
        send_bytes(201, 0, 50, 1'b1);
        p1 = pkt_id;
        send_pkt();
        chk("R10 restart count", {24'b0, reg_rdata[31:24]}, 32'd1);
        rd_chk("R10 restart data", 0, 10, p1);

        // R3: overflow leaves slot 7 intact
        reg_write(32'h0000_817F);
        for (int j = 0; j < 8; j++) send_pkt();
        p8 = pkt_id - 1;
        chk("R3 full count", {24'b0, reg_rdata[31:24]}, 32'd8);
        chk("R3 no overflow yet", {31'b0, reg_rdata[11]}, 32'd0);
        send_pkt();
        chk("R3 count held", {24'b0, reg_rdata[31:24]}, 32'd8);
        chk("R3 overflow flag", {31'b0, reg_rdata[11]}, 32'd1);
        rd_chk("R3 slot7 first", 7, 0, p8);
        rd_chk("R3 slot7 last", 7, 187, p8);

        // R9: run low holds capture in reset
        reg_write(32'h0000_0002);
        chk("R9 halted word", reg_rdata, 32'h0000_0002);
        send_pkt();
        chk("R9 input ignored", reg_rdata, 32'h0000_0002);
        reg_write(32'h0000_8002);
        send_pkt();
        chk("R9 resumed", reg_rdata, 32'h0100_8002);

        // R7 / R5: lock status and its mask
        @(negedge clk);
        lock_in = 1'b1;
        @(negedge clk);
        chk("R7 lock bit", {31'b0, reg_rdata[9]}, 32'd1);
        chk("R5 lock irq", {31'b0, irq}, 32'd1);
        reg_write(32'h0000_9002);
        chk("R5 lock masked", {31'b0, irq}, 32'd0);
        lock_in = 1'b0;
        @(negedge clk);
        chk("R7 lock cleared", {31'b0, reg_rdata[9]}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule